// File: doc/BRIEF.md
# Serial PCM Port with Frame-Sync Format Detection

This block moves 8-bit companded samples between a codec core and a bit-serial PCM highway. On the transmit side it shifts a code out MSB first on each frame. It raises an output-enable for an external three-state buffer while it owns the line, and it pulls an active-low slot strobe for the same span. On the receive side it collects 8 bits from the serial input and hands the assembled byte to the core with a one-cycle valid pulse.

The bit clocks, frame syncs and serial input all arrive asynchronously. The block samples them in a fast system clock domain through two-flop synchronisers, and it finds edges by comparing successive samples. The system clock must run at least eight times faster than the fastest bit clock.

The width of the transmit sync picks between a short and a long frame format. The new format governs the frames that follow. In the long format, the line is switched on and off by whichever of two events comes later. A static input lets the receive path borrow the transmit bit clock. A receive sync exactly two bit periods wide is flagged so that the decoder can treat the last bit as lost.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the port is in short format (long_mode = 0), tx_data_en = 0, tx_slot_n = 1, tx_data = 0 and rx_valid = 0.
- R2: In short format, if the transmit sync is high at a falling transmit bit-clock edge, the next rising edge enables the line with the MSB. Each of the next seven rising edges presents the next lower bit. The falling edge after the eighth rising edge releases the line.
- R3: In long format, the line is enabled with the MSB at the later of the transmit sync rising and the bit clock rising. A sync that rises while the bit clock is low leaves the line released until the next rising edge.
- R4: In long format, the line is released at the later of two events: the falling bit-clock edge after the eighth rising edge, and the transmit sync going low. Until release, the LSB stays on the line.
- R5: Each frame sends the tx_code value captured at the start of the previous frame. The first frame after reset sends 8'h00.
- R6: tx_slot_n is low exactly while tx_data_en is high. tx_data is 0 whenever tx_data_en is low.
- R7: In short format, if the receive sync is high at a falling receive bit-clock edge, the next eight falling edges latch the serial input, MSB first.
- R8: In long format, a rising receive sync causes the next eight falling receive bit-clock edges to latch the serial input, MSB first.
- R9: A transmit sync that spans one falling bit-clock edge selects short format. A sync that spans two or more selects long format. The choice takes effect when that sync falls and holds until the next sync falls.
- R10: rx_lsb_lost is 1 with a received byte when the receive sync for that frame spanned exactly two falling bit-clock edges and has already fallen. Otherwise it is 0.
- R11: With sync_mode = 1 the receive path is clocked by tx_bclk and rx_bclk is ignored. With sync_mode = 0 it uses rx_bclk.
- R12: rx_valid pulses for exactly one system cycle per received byte. rx_data holds that byte until the next one arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_mode | input | 1 | 1: receive path uses the transmit bit clock |
| tx_bclk | input | 1 | Transmit bit clock (asynchronous) |
| tx_fsync | input | 1 | Transmit frame sync (asynchronous) |
| tx_code | input | 8 | Code to be sent in the next frame |
| tx_data | output | 1 | Serial transmit bit, 0 when released |
| tx_data_en | output | 1 | Enable for the external three-state line buffer |
| tx_slot_n | output | 1 | Active-low transmit slot strobe |
| rx_bclk | input | 1 | Receive bit clock (asynchronous) |
| rx_fsync | input | 1 | Receive frame sync (asynchronous) |
| rx_din | input | 1 | Serial receive data |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data updates |
| rx_lsb_lost | output | 1 | Last bit of rx_data is a placeholder |
| long_mode | output | 1 | Currently detected frame format (1 = long) |

## Verification
In the short format, the falling edge that releases the transmit line is the same edge that latches the eighth receive bit. The line release and the receive valid pulse therefore land in the same system cycle. The bench drives both syncs with identical timing from one bit clock, so every frame provokes that collision. On each frame it judges both outcomes: the enable must be low at the sample after that edge, and exactly one new byte must have been delivered with the right value. Frames in long format, with syncs held past the eighth bit or raised late, move the two events apart and confirm that each one keeps its own rule.

// File: rtl/pcm_port_pkg.sv
// Shared types for the serial PCM port.
package pcm_port_pkg;

    // Transmit sequencer states.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    // Bit positions inside the synchroniser vector.
    localparam int unsigned SIG_TX_BCLK = 0;
    localparam int unsigned SIG_TX_FS   = 1;
    localparam int unsigned SIG_RX_BCLK = 2;
    localparam int unsigned SIG_RX_FS   = 3;
    localparam int unsigned SIG_RX_DIN  = 4;
    localparam int unsigned SIG_COUNT   = 5;
    localparam int unsigned SIG_EDGES   = 4;

endpackage

// File: rtl/pcm_sync_edge.sv
// Multi-bit synchroniser with change detection.
// Brings N asynchronous inputs into clk through STAGES flops. For the lowest
// EDGE_N bits it also flags a change between successive synchronised samples.
// Assumes each input holds for several clk cycles between transitions.
module pcm_sync_edge #(
    parameter int unsigned N      = 5,
    parameter int unsigned EDGE_N = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      raw,
    output logic [N-1:0]      lvl,
    output logic [EDGE_N-1:0] tgl
);
    logic [N-1:0]      stage [STAGES];
    logic [EDGE_N-1:0] prev;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage[s] <= '0;
        end else begin
            stage[0] <= raw;
            for (int s = 1; s < int'(STAGES); s++) stage[s] <= stage[s-1];
        end
    end

    assign lvl = stage[STAGES-1];

    // Keep the previous sample of the edge-bearing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl[EDGE_N-1:0];
    end

    assign tgl = prev ^ lvl[EDGE_N-1:0];
endmodule

// File: rtl/pcm_sync_width.sv
// Frame-sync width meter.
// Counts the falling bit-clock edges seen while a sync is high, and latches
// the count when the sync falls. With CLEAR_AT_START set, the latched value is
// cleared when a new sync rises, so it only describes a sync that has ended.
module pcm_sync_width #(
    parameter int unsigned CW             = 4,
    parameter bit          CLEAR_AT_START = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_fall,
    input  logic          fs_lvl,
    input  logic          fs_rise,
    input  logic          fs_fall,
    output logic [CW-1:0] width
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt;

    // Count edges during the sync and capture the total on its trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            width <= '0;
        end else if (fs_fall) begin
            width <= cnt;
            cnt   <= '0;
        end else begin
            if (CLEAR_AT_START && fs_rise) width <= '0;
            if (bclk_fall && fs_lvl && cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcm_tx_shifter.sv
// Transmit slot sequencer.
// Short format: arms when the sync is high at a falling edge, drives from the
// next rising edge. Long format: drives from the later of the sync rising and
// the bit clock rising. The line is released after the last bit on a falling
// edge, and in long format also not before the sync is low.
// Assumes edge strobes last one clk cycle.
module pcm_tx_shifter
    import pcm_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         long_mode,
    input  logic         bclk_lvl,
    input  logic         bclk_rise,
    input  logic         bclk_fall,
    input  logic         fs_lvl,
    input  logic         fs_rise,
    input  logic [W-1:0] code_in,
    output logic         tx_bit,
    output logic         tx_en
);
    localparam int unsigned IW = $clog2(W);
    localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

    tx_state_e     st;
    logic [W-1:0]  shreg;
    logic [W-1:0]  hold;
    logic [IW-1:0] idx;
    logic          tail;
    logic          at_last;

    assign at_last = (idx == LAST_IDX);

    // Sequence arming, bit shifting and release of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            shreg <= '0;
            hold  <= '0;
            idx   <= '0;
            tail  <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    idx  <= '0;
                    tail <= 1'b0;
                    if (long_mode && fs_rise) begin
                        shreg <= hold;
                        hold  <= code_in;
                        if (bclk_lvl) begin
                            tx_en <= 1'b1;
                            st    <= TX_SHIFT;
                        end else begin
                            st <= TX_ARMED;
                        end
                    end else if (!long_mode && bclk_fall && fs_lvl) begin
                        shreg <= hold;
                        hold  <= code_in;
                        st    <= TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (bclk_rise) begin
                        tx_en <= 1'b1;
                        st    <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (!at_last) begin
                        if (bclk_rise) begin
                            shreg <= {shreg[W-2:0], 1'b0};
                            idx   <= idx + 1'b1;
                        end
                    end else if (bclk_fall || tail) begin
                        if (!long_mode || !fs_lvl) begin
                            tx_en <= 1'b0;
                            tail  <= 1'b0;
                            st    <= TX_IDLE;
                        end else begin
                            tail <= 1'b1;
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign tx_bit = tx_en & shreg[W-1];
endmodule

// File: rtl/pcm_rx_shifter.sv
// Receive slot collector.
// Short format arms on a falling edge with the sync high; long format arms on
// the sync rising. Either way the next W falling edges latch data MSB first,
// then the byte is published with a one-cycle valid pulse.
module pcm_rx_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         long_mode,
    input  logic         bclk_fall,
    input  logic         fs_lvl,
    input  logic         fs_rise,
    input  logic         din,
    input  logic         two_wide,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         rx_lsb_lost
);
    localparam int unsigned IW = $clog2(W);
    localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

    logic          busy;
    logic [IW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic          start;

    assign start = long_mode ? fs_rise : (bclk_fall && fs_lvl);

    // Arm on the sync, collect W bits, publish the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            cnt         <= '0;
            shreg       <= '0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            rx_lsb_lost <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                end
            end else if (bclk_fall) begin
                shreg <= {shreg[W-2:0], din};
                cnt   <= cnt + 1'b1;
                if (cnt == LAST_IDX) begin
                    rx_data     <= {shreg[W-2:0], din};
                    rx_valid    <= 1'b1;
                    rx_lsb_lost <= two_wide;
                    busy        <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
// Serial PCM port, top level.
// Synchronises the bit clocks, syncs and serial input into clk, detects the
// frame format from the transmit sync width, and runs one transmit and one
// receive slot per frame. Assumes clk is at least 8x the fastest bit clock.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WIDTH_CW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [CODE_W-1:0] tx_code,
    output logic              tx_data,
    output logic              tx_data_en,
    output logic              tx_slot_n,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_din,
    output logic [CODE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_lsb_lost,
    output logic              long_mode
);
    localparam logic [WIDTH_CW-1:0] TWO_EDGES = WIDTH_CW'(2);

    logic [SIG_COUNT-1:0] raw_in;
    logic [SIG_COUNT-1:0] s_lvl;
    logic [SIG_EDGES-1:0] s_tgl;

    logic tx_rise, tx_fall, tx_fs_rise, tx_fs_fall;
    logic rx_own_fall, rx_fall, rx_fs_rise, rx_fs_fall;
    logic [WIDTH_CW-1:0] tx_width, rx_width;
    logic rx_two;

    assign raw_in[SIG_TX_BCLK] = tx_bclk;
    assign raw_in[SIG_TX_FS]   = tx_fsync;
    assign raw_in[SIG_RX_BCLK] = rx_bclk;
    assign raw_in[SIG_RX_FS]   = rx_fsync;
    assign raw_in[SIG_RX_DIN]  = rx_din;

    pcm_sync_edge #(
        .N(SIG_COUNT), .EDGE_N(SIG_EDGES), .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_in), .lvl(s_lvl), .tgl(s_tgl)
    );

    assign tx_rise     = s_tgl[SIG_TX_BCLK] &  s_lvl[SIG_TX_BCLK];
    assign tx_fall     = s_tgl[SIG_TX_BCLK] & ~s_lvl[SIG_TX_BCLK];
    assign tx_fs_rise  = s_tgl[SIG_TX_FS]   &  s_lvl[SIG_TX_FS];
    assign tx_fs_fall  = s_tgl[SIG_TX_FS]   & ~s_lvl[SIG_TX_FS];
    assign rx_own_fall = s_tgl[SIG_RX_BCLK] & ~s_lvl[SIG_RX_BCLK];
    assign rx_fs_rise  = s_tgl[SIG_RX_FS]   &  s_lvl[SIG_RX_FS];
    assign rx_fs_fall  = s_tgl[SIG_RX_FS]   & ~s_lvl[SIG_RX_FS];

    // In synchronous operation the transmit bit clock times the receive path.
    assign rx_fall = sync_mode ? tx_fall : rx_own_fall;

    pcm_sync_width #(.CW(WIDTH_CW), .CLEAR_AT_START(1'b0)) u_tx_width (
        .clk(clk), .rst_n(rst_n), .bclk_fall(tx_fall), .fs_lvl(s_lvl[SIG_TX_FS]),
        .fs_rise(tx_fs_rise), .fs_fall(tx_fs_fall), .width(tx_width)
    );

    pcm_sync_width #(.CW(WIDTH_CW), .CLEAR_AT_START(1'b1)) u_rx_width (
        .clk(clk), .rst_n(rst_n), .bclk_fall(rx_fall), .fs_lvl(s_lvl[SIG_RX_FS]),
        .fs_rise(rx_fs_rise), .fs_fall(rx_fs_fall), .width(rx_width)
    );

    assign long_mode = (tx_width >= TWO_EDGES);
    assign rx_two    = (rx_width == TWO_EDGES);

    pcm_tx_shifter #(.W(CODE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
        .bclk_lvl(s_lvl[SIG_TX_BCLK]), .bclk_rise(tx_rise), .bclk_fall(tx_fall),
        .fs_lvl(s_lvl[SIG_TX_FS]), .fs_rise(tx_fs_rise), .code_in(tx_code),
        .tx_bit(tx_data), .tx_en(tx_data_en)
    );

    assign tx_slot_n = ~tx_data_en;

    pcm_rx_shifter #(.W(CODE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .bclk_fall(rx_fall),
        .fs_lvl(s_lvl[SIG_RX_FS]), .fs_rise(rx_fs_rise), .din(s_lvl[SIG_RX_DIN]),
        .two_wide(rx_two), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_lsb_lost(rx_lsb_lost)
    );
endmodule

// File: rtl/pcm_port_checker.sv
// Temporal checks on the serial PCM port, attached by bind.
module pcm_port_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_data,
    input logic tx_data_en,
    input logic rx_valid,
    input logic long_mode,
    input logic tx_rise,
    input logic tx_fall,
    input logic tx_fs_rise,
    input logic tx_fs_fall,
    input logic rx_fall
);
    // The line may only turn on after a bit-clock or sync rising edge.
    assert_enable_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_data_en) |-> $past(tx_rise || tx_fs_rise));

    // The line may only turn off after a bit-clock falling edge or sync fall.
    assert_release_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_data_en) |-> $past(tx_fall || tx_fs_fall));

    // While driven, the bit only changes after a rising bit-clock edge.
    assert_bit_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data_en && $past(tx_data_en) && !$past(tx_rise)) |-> $stable(tx_data));

    // The detected format only changes after the transmit sync falls.
    assert_mode_on_sync_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (long_mode != $past(long_mode)) |-> $past(tx_fs_fall));

    // A byte is published only after a receive falling edge.
    assert_valid_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_fall));

    // The valid strobe lasts a single cycle.
    assert_valid_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_serial_port pcm_port_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_data_en(tx_data_en),
    .rx_valid(rx_valid), .long_mode(long_mode), .tx_rise(tx_rise),
    .tx_fall(tx_fall), .tx_fs_rise(tx_fs_rise), .tx_fs_fall(tx_fs_fall),
    .rx_fall(rx_fall)
);

// File: tb/tb_pcm_serial_port.sv
// Frame-level bench: each frame drives both syncs from one bit clock and
// checks the transmit line every half bit against arithmetic expectations.
module tb_pcm_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b1;
    logic       tx_bclk = 1'b0, tx_fsync = 1'b0, rx_bclk = 1'b0, rx_fsync = 1'b0, rx_din = 1'b0;
    logic [7:0] tx_code = 8'h00;
    logic       tx_data, tx_data_en, tx_slot_n, rx_valid, rx_lsb_lost, long_mode;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    bit lm = 1'b0;
    logic [7:0] prev_code = 8'h00;

    always #4 clk = ~clk;

    pcm_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tx_bclk(tx_bclk),
        .tx_fsync(tx_fsync), .tx_code(tx_code), .tx_data(tx_data),
        .tx_data_en(tx_data_en), .tx_slot_n(tx_slot_n), .rx_bclk(rx_bclk),
        .rx_fsync(rx_fsync), .rx_din(rx_din), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_lsb_lost(rx_lsb_lost), .long_mode(long_mode)
    );

    // Count published bytes.
    always @(posedge clk) if (rst_n && rx_valid) vcnt <= vcnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half(input logic lvl, input logic fs, input logic dr);
        @(negedge clk);
        tx_bclk  = lvl;
        rx_bclk  = sync_mode ? 1'b0 : lvl;
        tx_fsync = fs;
        rx_fsync = fs;
        rx_din   = dr;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_tx(input bit exp_en, input int idx, input string req);
        check(tx_data_en == exp_en, {req, " line enable"}, tx_data_en, exp_en);
        check(tx_slot_n == !exp_en, "R6 slot strobe", tx_slot_n, !exp_en);
        if (exp_en)
            check(tx_data == prev_code[7-idx], {req, " R5 bit"}, tx_data, prev_code[7-idx]);
        else
            check(tx_data == 1'b0, "R6 idle bit", tx_data, 0);
    endtask

    task automatic run_frame(input int fs_len, input bit late,
                             input logic [7:0] code_in, input logic [7:0] rx_byte);
        int   last, v0, idx;
        bit   en_hi, en_lo;
        logic dr;
        string req;
        req = lm ? "R3/R4 long" : "R2 short";
        tx_code = code_in;
        v0 = vcnt;
        if (late) begin
            half(1'b1, 1'b0, 1'b0);
            half(1'b0, 1'b1, 1'b0);
            check(tx_data_en == 1'b0, "R3 late sync waits", tx_data_en, 0);
        end
        last = (fs_len + 1 > 9) ? fs_len + 1 : 9;
        for (int p = 0; p <= last; p++) begin
            if (lm) begin
                dr    = (p <= 7) ? rx_byte[7-p] : 1'b0;
                en_hi = (p <= 7) || (p < fs_len);
                en_lo = (p < 7) || (p < fs_len);
                idx   = (p > 7) ? 7 : p;
            end else begin
                dr    = (p >= 1 && p <= 8) ? rx_byte[8-p] : 1'b0;
                en_hi = (p >= 1 && p <= 8);
                en_lo = (p >= 1 && p <= 7);
                idx   = p - 1;
            end
            half(1'b1, p < fs_len, dr);
            check_tx(en_hi, idx, req);
            half(1'b0, p < fs_len, dr);
            check_tx(en_lo, idx, req);
        end
        half(1'b1, 1'b0, 1'b0);
        half(1'b0, 1'b0, 1'b0);
        check(rx_data == rx_byte, lm ? "R8 long receive" : "R7 short receive", rx_data, rx_byte);
        check(vcnt == v0 + 1, "R12 one valid per byte", vcnt - v0, 1);
        check(rx_lsb_lost == (fs_len == 2), "R10 lost LSB flag", rx_lsb_lost, fs_len == 2);
        check(long_mode == (fs_len >= 2), "R9 format detect", long_mode, fs_len >= 2);
        lm = (fs_len >= 2);
        prev_code = code_in;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(long_mode == 1'b0, "R1 short after reset", long_mode, 0);
        check(tx_data_en == 1'b0, "R1 line released", tx_data_en, 0);
        check(tx_slot_n == 1'b1, "R1 slot high", tx_slot_n, 1);
        check(tx_data == 1'b0, "R1 bit low", tx_data, 0);
        check(rx_valid == 1'b0, "R1 no valid", rx_valid, 0);
        half(1'b1, 1'b0, 1'b0);
        half(1'b0, 1'b0, 1'b0);

        // R11: synchronous mode, rx_bclk held low.
        sync_mode = 1'b1;
        run_frame(1, 1'b0, 8'hA5, 8'h3C);
        run_frame(1, 1'b0, 8'h5A, 8'hC3);
        run_frame(3, 1'b0, 8'h81, 8'h7E);
        run_frame(3, 1'b0, 8'h0F, 8'hE1);
        run_frame(2, 1'b0, 8'hF0, 8'h96);
        run_frame(9, 1'b0, 8'h33, 8'h69);
        run_frame(8, 1'b1, 8'hCC, 8'h01);
        run_frame(1, 1'b0, 8'h7F, 8'h80);
        // R11: separate receive bit clock.
        sync_mode = 1'b0;
        run_frame(1, 1'b0, 8'hFE, 8'hAA);
        run_frame(4, 1'b0, 8'h55, 8'h5B);
        run_frame(9, 1'b1, 8'h18, 8'hE7);
        // Sweep of sync widths, codes and formats.
        for (int k = 0; k < 18; k++) begin
            sync_mode = k[0];
            run_frame((k % 3 == 0) ? 1 : ((k % 3 == 1) ? 3 : 2), 1'b0,
                      8'(k * 29 + 7), 8'(k * 53) ^ 8'hA6);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule